// File: doc/BRIEF.md
# Accumulator ALU Instruction Executor

This block runs one register-to-register arithmetic or logic instruction per clock. It holds four 16-bit accumulators and a one-bit Carry flag. The instruction is applied as follows:

1. Two accumulators, a source and a destination, are read.
2. A function generator forms a 16-bit result together with a carry bit. The carry bit starts from a base value chosen by the instruction. Arithmetic functions invert that base on a carry out of the most significant bit.
3. The 17-bit word {carry, result} passes through a shifter. The shifter can rotate the word one place left or right, or swap the bytes of the result.
4. A skip sensor tests the shifter output and raises a one-cycle skip pulse.
5. Unless the instruction's no-load bit is set, the shifted word is written into Carry and the destination accumulator.

Instructions arrive on a valid/ready stream. The block never applies back-pressure: `insn_ready` is high at all times. A word is consumed on every rising edge where `insn_valid` is high, so the upstream side may present a new word on every cycle. There is no stalling, and a word is never held across cycles. The accumulators and Carry are brought out on the ports for observation. The block produces a skip indication but contains no program counter, so acting on that indication belongs to the consumer.

In the field descriptions below, bit 0 is the most significant bit of a word, so `insn[15]` is bit 0.

Top module: `acc_alu_exec`

## Requirements
- R1: After reset, all four accumulators and Carry are zero, the skip output is low, and `insn_ready` is high.
- R2: A word is executed only if `insn_valid` is high and bit 0 (`insn[15]`) is 1. If `insn_valid` is low, or bit 0 is 0, no accumulator and no Carry changes, and the next cycle's skip output is low.
- R3: Bits 1-2 (`insn[14:13]`) select the source accumulator. Bits 3-4 (`insn[12:11]`) select the destination. Only the destination accumulator is written.
- R4: Bits 10-11 (`insn[5:4]`) select the carry base: 00 is current Carry, 01 is zero, 10 is one, and 11 is the complement of Carry.
- R5: The logical functions pass the base value through as the carry bit. Complement (code 000) gives ~S, move (code 010) gives S, and AND (code 111) gives S&D.
- R6: The arithmetic functions invert the base exactly when there is a carry out:
  - negate (001) gives -S and inverts when S==0;
  - increment (011) gives S+1 and inverts when S==0xFFFF;
  - add-complement (100) gives D+~S and inverts when D>S unsigned;
  - subtract (101) gives D-S and inverts when D>=S unsigned;
  - add (110) gives D+S and inverts when the 17-bit sum overflows.
- R7: Bits 5-7 (`insn[10:8]`) hold the function code, and the results are those listed in R5 and R6. For example, word 0o133000 adds AC1 into AC2.
- R8: Bits 8-9 (`insn[7:6]`) select the shift:
  - 00: no shift;
  - 01: rotate {c,r} left one place, so the result MSB goes into carry and carry goes into the LSB;
  - 10: rotate right one place, so the LSB goes into carry and carry goes into the MSB;
  - 11: swap the result bytes and leave the carry unchanged.
- R9: Bits 13-15 (`insn[2:0]`) select a skip test on the shifter output:
  - 000: never;
  - 001: always;
  - 010: carry==0;
  - 011: carry!=0;
  - 100: result==0;
  - 101: result!=0;
  - 110: carry==0 or result==0;
  - 111: carry!=0 and result!=0.
- R10: When bit 12 (`insn[3]`) is 1, no accumulator and no Carry is written, but the skip is still reported.
- R11: The load into Carry and the destination happens on the edge that accepts the word. `skip` is high for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| insn_valid | input | 1 | Instruction word present |
| insn_ready | output | 1 | Always 1; the block never stalls |
| insn | input | 16 | Instruction word, bit 0 = `insn[15]` |
| skip | output | 1 | One-cycle skip pulse for the last accepted word |
| carry | output | 1 | Carry flag |
| acc_flat | output | 64 | Accumulator k at bits [16k+15:16k] |

## Verification
Two functions can act on the same word in the same cycle: the skip test and the load. They may or may not be acted on together, because the no-load bit suppresses the write while the skip still fires from the same shifter output. The bench sweeps every combination of function, shift, carry base, skip code and no-load bit, with accumulator contents preloaded through the block's own rotate-left instructions. After each word it compares the skip pulse, Carry and all four accumulators against an arithmetic model. The comparison shows that a skip is judged on the shifted word and that a suppressed load changes no state.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int INSN_W  = 16;
  localparam int NUM_ACC = 4;
  localparam int SEL_W   = $clog2(NUM_ACC);

  typedef enum logic [2:0] {
    FN_COM = 3'd0, FN_NEG = 3'd1, FN_MOV = 3'd2, FN_INC = 3'd3,
    FN_ADC = 3'd4, FN_SUB = 3'd5, FN_ADD = 3'd6, FN_AND = 3'd7
  } fn_e;

  typedef enum logic [1:0] {
    SH_NONE = 2'd0, SH_ROL = 2'd1, SH_ROR = 2'd2, SH_SWAP = 2'd3
  } sh_e;

  typedef enum logic [1:0] {
    CB_KEEP = 2'd0, CB_ZERO = 2'd1, CB_ONE = 2'd2, CB_FLIP = 2'd3
  } cb_e;

  typedef enum logic [2:0] {
    SK_NEVER = 3'd0, SK_ALWAYS = 3'd1, SK_CZ = 3'd2, SK_CNZ = 3'd3,
    SK_RZ = 3'd4, SK_RNZ = 3'd5, SK_EITHER_Z = 3'd6, SK_BOTH_NZ = 3'd7
  } sk_e;

  typedef struct packed {
    logic             exec;
    logic [SEL_W-1:0] src;
    logic [SEL_W-1:0] dst;
    fn_e              fn;
    sh_e              sh;
    cb_e              cb;
    logic             noload;
    sk_e              sk;
  } dec_t;

  // Field split: MSB first, bit 0 of the word is insn[15].
  function automatic dec_t decode(input logic [INSN_W-1:0] w);
    dec_t d;
    d.exec   = w[15];
    d.src    = w[14:13];
    d.dst    = w[12:11];
    d.fn     = fn_e'(w[10:8]);
    d.sh     = sh_e'(w[7:6]);
    d.cb     = cb_e'(w[5:4]);
    d.noload = w[3];
    d.sk     = sk_e'(w[2:0]);
    return d;
  endfunction
endpackage

// File: rtl/acc_funcgen.sv
module acc_funcgen
  import acc_alu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  fn_e               fn,
  input  cb_e               cb,
  input  logic              carry_in,
  input  logic [WORD_W-1:0] src_val,
  input  logic [WORD_W-1:0] dst_val,
  output logic [WORD_W-1:0] res,
  output logic              cy
);
  localparam int EXT_W = WORD_W + 1;

  logic             base;
  logic             arith;
  logic [EXT_W-1:0] ext;

  always_comb begin
    unique case (cb)
      CB_KEEP: base = carry_in;
      CB_ZERO: base = 1'b0;
      CB_ONE:  base = 1'b1;
      default: base = ~carry_in;
    endcase
  end

  always_comb begin
    arith = 1'b1;
    unique case (fn)
      FN_COM: begin ext = {1'b0, ~src_val};           arith = 1'b0; end
      FN_NEG:       ext = {1'b0, ~src_val} + EXT_W'(1);
      FN_MOV: begin ext = {1'b0, src_val};            arith = 1'b0; end
      FN_INC:       ext = {1'b0, src_val} + EXT_W'(1);
      FN_ADC:       ext = {1'b0, dst_val} + {1'b0, ~src_val};
      FN_SUB:       ext = {1'b0, dst_val} + {1'b0, ~src_val} + EXT_W'(1);
      FN_ADD:       ext = {1'b0, dst_val} + {1'b0, src_val};
      default: begin ext = {1'b0, src_val & dst_val}; arith = 1'b0; end
    endcase
  end

  assign res = ext[WORD_W-1:0];
  assign cy  = base ^ (arith & ext[WORD_W]);

  always_comb begin
    if (fn == FN_AND && cb == CB_KEEP)
      p_logic_pass_r5: assert (cy == carry_in);
    if (fn == FN_SUB && cb == CB_ZERO)
      p_sub_cmp_r6: assert (cy == (dst_val >= src_val));
    if (fn == FN_ADC && cb == CB_ZERO)
      p_adc_cmp_r6: assert (cy == (dst_val > src_val));
  end
endmodule

// File: rtl/acc_shifter.sv
module acc_shifter
  import acc_alu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  sh_e               sh,
  input  logic              c_in,
  input  logic [WORD_W-1:0] r_in,
  output logic              c_out,
  output logic [WORD_W-1:0] r_out
);
  localparam int HALF = WORD_W / 2;

  always_comb begin
    unique case (sh)
      SH_NONE: {c_out, r_out} = {c_in, r_in};
      SH_ROL:  {c_out, r_out} = {r_in, c_in};
      SH_ROR:  {c_out, r_out} = {r_in[0], c_in, r_in[WORD_W-1:1]};
      default: {c_out, r_out} = {c_in, r_in[HALF-1:0], r_in[WORD_W-1:HALF]};
    endcase
  end

  always_comb begin
    p_bits_kept_r8: assert ($countones({c_out, r_out}) == $countones({c_in, r_in}));
    if (sh == SH_SWAP)
      p_swap_carry_r8: assert (c_out == c_in);
  end
endmodule

// File: rtl/acc_skip_sense.sv
module acc_skip_sense
  import acc_alu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  sk_e               sk,
  input  logic              c,
  input  logic [WORD_W-1:0] r,
  output logic              hit
);
  logic c_z, r_z;

  assign c_z = ~c;
  assign r_z = (r == '0);

  always_comb begin
    unique case (sk)
      SK_NEVER:    hit = 1'b0;
      SK_ALWAYS:   hit = 1'b1;
      SK_CZ:       hit = c_z;
      SK_CNZ:      hit = ~c_z;
      SK_RZ:       hit = r_z;
      SK_RNZ:      hit = ~r_z;
      SK_EITHER_Z: hit = c_z | r_z;
      default:     hit = ~c_z & ~r_z;
    endcase
  end

  always_comb begin
    if (sk == SK_NEVER)    p_never_r9:  assert (!hit);
    if (sk == SK_ALWAYS)   p_always_r9: assert (hit);
    if (sk == SK_BOTH_NZ && hit) p_both_r9: assert (c && (r != '0));
  end
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      insn_valid,
  output logic                      insn_ready,
  input  logic [INSN_W-1:0]         insn,
  output logic                      skip,
  output logic                      carry,
  output logic [NUM_ACC*WORD_W-1:0] acc_flat
);
  dec_t              dec;
  logic              fire;
  logic [WORD_W-1:0] acc_q [NUM_ACC];
  logic              carry_q, skip_q;
  logic [WORD_W-1:0] fg_res, sh_res;
  logic              fg_cy, sh_cy, hit;

  assign insn_ready = 1'b1;
  assign dec  = decode(insn);
  assign fire = insn_valid && insn_ready && dec.exec;

  acc_funcgen #(.WORD_W(WORD_W)) u_fg (
    .fn(dec.fn), .cb(dec.cb), .carry_in(carry_q),
    .src_val(acc_q[dec.src]), .dst_val(acc_q[dec.dst]),
    .res(fg_res), .cy(fg_cy)
  );

  acc_shifter #(.WORD_W(WORD_W)) u_sh (
    .sh(dec.sh), .c_in(fg_cy), .r_in(fg_res), .c_out(sh_cy), .r_out(sh_res)
  );

  acc_skip_sense #(.WORD_W(WORD_W)) u_sk (
    .sk(dec.sk), .c(sh_cy), .r(sh_res), .hit(hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NUM_ACC; k++) acc_q[k] <= '0;
      carry_q <= 1'b0;
      skip_q  <= 1'b0;
    end else begin
      skip_q <= fire & hit;
      if (fire && !dec.noload) begin
        acc_q[dec.dst] <= sh_res;
        carry_q        <= sh_cy;
      end
    end
  end

  assign skip  = skip_q;
  assign carry = carry_q;

  for (genvar k = 0; k < NUM_ACC; k++) begin : g_obs
    assign acc_flat[k*WORD_W +: WORD_W] = acc_q[k];

    p_only_dst_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(fire && !dec.noload && dec.dst == SEL_W'(k)) |=> $stable(acc_q[k]));
  end

  p_ignore_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(carry_q) && !skip_q));

  p_noload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && dec.noload) |=> $stable(carry_q));

  p_skip_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |-> $past(fire));
endmodule

// File: tb/acc_alu_exec_test.sv
module acc_alu_exec_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        insn_valid = 1'b0;
  logic        insn_ready;
  logic [15:0] insn = '0;
  logic        skip, carry;
  logic [63:0] acc_flat;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  logic [15:0] m_acc [4];
  logic        m_c, m_skip;
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu_exec uut (
    .clk(clk), .rst_n(rst_n), .insn_valid(insn_valid), .insn_ready(insn_ready),
    .insn(insn), .skip(skip), .carry(carry), .acc_flat(acc_flat)
  );

  function automatic logic [15:0] mk(input int s, input int d, input int f,
      input int sh, input int cb, input int nl, input int sk);
    return {1'b1, 2'(s), 2'(d), 3'(f), 2'(sh), 2'(cb), 1'(nl), 3'(sk)};
  endfunction

  // Reference model written from the requirement text.
  task automatic model(input logic v, input logic [15:0] w);
    int s, d, f, sh, cb, sk;
    logic base, co, c2;
    logic [15:0] a, b, r, r2;
    int unsigned sum;
    m_skip = 1'b0;
    if (!v || !w[15]) return;              // R2
    s = int'(w[14:13]); d = int'(w[12:11]); // R3
    f = int'(w[10:8]); sh = int'(w[7:6]); cb = int'(w[5:4]); sk = int'(w[2:0]);
    a = m_acc[s]; b = m_acc[d];
    base = (cb == 0) ? m_c : (cb == 1) ? 1'b0 : (cb == 2) ? 1'b1 : !m_c; // R4
    co = 1'b0;
    case (f)                                // R5 R6 R7
      0: r = ~a;
      1: begin sum = 32'h10000 - int'(a); r = sum[15:0]; co = (a == 0); end
      2: r = a;
      3: begin sum = int'(a) + 1; r = sum[15:0]; co = (a == 16'hFFFF); end
      4: begin r = b + ~a; co = (b > a); end
      5: begin r = b - a; co = (b >= a); end
      6: begin sum = int'(a) + int'(b); r = sum[15:0]; co = sum > 32'hFFFF; end
      default: r = a & b;
    endcase
    c2 = base ^ co;
    case (sh)                               // R8
      0: r2 = r;
      1: begin r2 = (r << 1) | 16'(c2); c2 = r[15]; end
      2: begin r2 = (r >> 1) | (16'(c2) << 15); c2 = r[0]; end
      default: r2 = {r[7:0], r[15:8]};
    endcase
    case (sk)                               // R9
      0: m_skip = 0;
      1: m_skip = 1;
      2: m_skip = !c2;
      3: m_skip = c2;
      4: m_skip = (r2 == 0);
      5: m_skip = (r2 != 0);
      6: m_skip = !c2 || (r2 == 0);
      default: m_skip = c2 && (r2 != 0);
    endcase
    if (!w[3]) begin m_acc[d] = r2; m_c = c2; end  // R10
  endtask

  task automatic compare(input string tag);
    tests++;
    if (skip !== m_skip) begin
      fails++;
      $display("FAIL %s skip: actual %b expected %b", tag, skip, m_skip);
    end
    if (carry !== m_c) begin
      fails++;
      $display("FAIL %s carry: actual %b expected %b", tag, carry, m_c);
    end
    for (int k = 0; k < 4; k++)
      if (acc_flat[k*16 +: 16] !== m_acc[k]) begin
        fails++;
        $display("FAIL %s acc%0d: actual %h expected %h", tag, k, acc_flat[k*16 +: 16], m_acc[k]);
      end
  endtask

  // Drive at a falling edge; result is sampled at the next falling edge (R11).
  task automatic run(input logic v, input logic [15:0] w, input string tag);
    insn_valid = v; insn = w;
    model(v, w);
    @(posedge clk);
    @(negedge clk);
    insn_valid = 1'b0;
    compare(tag);
  endtask

  // Preload: clear with subtract/base one, then shift value in MSB first.
  task automatic load(input int k, input logic [15:0] v);
    run(1'b1, mk(k, k, 5, 0, 2, 0, 0), "R6");
    for (int i = 15; i >= 0; i--)
      run(1'b1, mk(k, k, 2, 1, v[i] ? 2 : 1, 0, 0), "R8");
  endtask

  task automatic step_lfsr();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  initial begin
    for (int k = 0; k < 4; k++) m_acc[k] = '0;
    m_c = 1'b0; m_skip = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    tests++;
    if (acc_flat !== 64'd0 || carry !== 1'b0 || skip !== 1'b0 || insn_ready !== 1'b1) begin
      fails++;
      $display("FAIL R1 reset: actual acc=%h c=%b s=%b rdy=%b expected 0,0,0,1",
               acc_flat, carry, skip, insn_ready);
    end

    load(1, 16'h0001); load(2, 16'hFFFF);
    run(1'b1, 16'o133000, "R7");           // add AC1 into AC2: 0, carry flips
    load(1, 16'h4000); load(2, 16'h4000);
    run(1'b1, 16'o133102, "R9");           // add, rotate left, skip on carry zero
    run(1'b1, 16'o133112, "R10");          // same, no load
    load(3, 16'h1234);
    run(1'b1, mk(3, 0, 2, 3, 0, 0, 5), "R8");  // byte swap
    run(1'b1, mk(0, 0, 1, 0, 1, 0, 4), "R6");  // negate of non-zero
    run(1'b1, mk(2, 2, 5, 0, 0, 0, 4), "R6");  // subtract self -> zero, flip
    run(1'b1, mk(2, 1, 1, 0, 0, 0, 1), "R6");  // negate zero
    load(0, 16'hFFFF);
    run(1'b1, mk(0, 3, 3, 0, 1, 0, 2), "R6");  // increment 0xFFFF
    // R2: ignored words
    run(1'b1, 16'h7FFF, "R2");
    run(1'b0, 16'hFFF9, "R2");
    run(1'b0, 16'o133001, "R2");

    // Sweep over every field combination (R3 R4 R5 R6 R7 R8 R9 R10 R11)
    for (int combo = 0; combo < 2048; combo++) begin
      if (combo % 64 == 0)
        for (int k = 0; k < 4; k++) begin
          step_lfsr();
          load(k, (k == 0 && combo % 128 == 0) ? 16'h0000 : lfsr);
        end
      step_lfsr();
      run(1'b1, mk(int'(lfsr[1:0]), int'(lfsr[3:2]), combo % 8, (combo / 8) % 4,
                   (combo / 32) % 4, (combo / 128) % 2, (combo / 256) % 8), "R7");
      if (combo % 97 == 0) run(1'b1, {1'b0, lfsr[14:0]}, "R2");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule